// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel attached to a timer counter that lives elsewhere. A CPU-side bus writes the compare value. On every timer tick the channel compares the counter with its active compare value. A hit raises an interrupt flag and applies the selected set, clear or toggle action to an internal waveform bit. In clear-on-compare mode the hit also asks the counter to restart. The waveform bit can be routed onto a port pin in place of the ordinary port data.

In the two PWM modes the bus writes a shadow register. The active value takes the shadow only at one end of the count, which keeps each period whole. In the other two modes the bus writes the active value directly. A force strobe applies the compare action without a real hit, and only in the modes without PWM. A write to the counter opens a short window in which hits are ignored. This lets software load the counter with the compare value without raising a spurious event. That window is held by a two-state guard machine. In state ARMED, a counter write moves it to BLOCKED. In state BLOCKED, a timer tick without a new counter write moves it back to ARMED. A counter write keeps it in BLOCKED.

Top module: `oc_unit`

## Requirements
- R1: After reset, `wave`, `flag`, `cnt_clear` and `cmp_rdata` are all 0.
- R2: With `wgm` = 0 (normal) or 1 (clear-on-compare), a `cmp_wr` sets the active compare value at the next clock edge. `cmp_rdata` then shows that value.
- R3: With `wgm` = 2 or 3 (PWM), a `cmp_wr` goes only to the shadow register, and `cmp_rdata` shows the shadow. The active value is unchanged except at a load point.
- R4: The load point is a tick with `at_bottom` high for `wgm` = 2, and a tick with `at_top` high for `wgm` = 3. At that point the active value takes the shadow value held before that edge.
- R5: A hit is a cycle with `tick` high, `cnt` equal to the active value and no suppression. A hit sets `flag` at the next edge. Writing one to `flag_clr` clears `flag`, and a hit in the same cycle wins.
- R6: On a hit, `cmo` selects the waveform action at the next edge. The encodings are 0 = no change, 1 = toggle, 2 = clear to 0, 3 = set to 1. `cmo` is not buffered: the value present in that cycle is used.
- R7: In modes 0 and 1, `force_oc` applies the `cmo` action to `wave` but sets no `flag` and raises no `cnt_clear`. In modes 2 and 3, `force_oc` has no effect on `wave`.
- R8: A `cnt_wr` suppresses any hit in its own cycle and in every cycle up to and including the next `tick`. This holds even when no tick arrives for many cycles.
- R9: `cnt_clear` is high, in the same cycle, exactly when a hit occurs with `wgm` = 1.
- R10: `pin_out` equals `wave` when `cmo` is non-zero and `pin_dir` is 1. Otherwise `pin_out` equals `pin_data`.
- R11: `wave` keeps its value when `wgm` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable for this cycle |
| cnt | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at its top value |
| at_bottom | input | 1 | Counter is at zero |
| wgm | input | 2 | Waveform mode: 0 normal, 1 clear-on-compare, 2 PWM loaded at bottom, 3 PWM loaded at top |
| cmo | input | 2 | Compare action: 0 none, 1 toggle, 2 clear, 3 set |
| cmp_wr | input | 1 | Bus write strobe for the compare value |
| cmp_wdata | input | 8 | Bus write data for the compare value |
| cmp_rdata | output | 8 | Bus read of the compare value |
| cnt_wr | input | 1 | Pulse marking a CPU write to the counter |
| force_oc | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| flag | output | 1 | Compare interrupt flag |
| cnt_clear | output | 1 | Counter restart request |
| wave | output | 1 | Internal waveform bit |
| pin_dir | input | 1 | Port direction bit, 1 = output |
| pin_data | input | 1 | Ordinary port data value |
| pin_out | output | 1 | Value driven on the pin |

## Verification
Random traffic keeps the counter and compare values in a narrow range, so hits are frequent. Mixing modes shows whether a write lands in the active or the shadow register. Mixing counter writes with ticks that are mostly idle shows whether suppression lasts until the next tick or only one clock. Directed sequences cover the rest:
- a counter write while the timer is stopped;
- forces in PWM modes;
- a flag clear in the same cycle as a hit;
- a shadow load at each end of the count.

Together they separate the set-wins-clear order and each mode's load point.

// File: rtl/oc_pkg.sv
package oc_pkg;
    typedef enum logic [1:0] {
        WGM_NORMAL  = 2'd0,
        WGM_CTC     = 2'd1,
        WGM_PWM_BOT = 2'd2,
        WGM_PWM_TOP = 2'd3
    } wgm_e;

    typedef enum logic [1:0] {
        CMO_OFF    = 2'd0,
        CMO_TOGGLE = 2'd1,
        CMO_CLEAR  = 2'd2,
        CMO_SET    = 2'd3
    } cmo_e;

    typedef enum logic {
        GUARD_ARMED   = 1'b0,
        GUARD_BLOCKED = 1'b1
    } guard_e;
endpackage

// File: rtl/oc_cmp_regs.sv
module oc_cmp_regs
    import oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wgm_e         wgm,
    input  logic         tick,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] act_o,
    output logic [W-1:0] rd_o
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;
    logic         is_pwm;
    logic         load_pt;

    always_comb begin
        is_pwm  = (wgm == WGM_PWM_BOT) || (wgm == WGM_PWM_TOP);
        load_pt = tick && (((wgm == WGM_PWM_BOT) && at_bottom) ||
                           ((wgm == WGM_PWM_TOP) && at_top));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en) shadow_q <= wdata;
            if (!is_pwm && wr_en)  active_q <= wdata;
            else if (load_pt)      active_q <= shadow_q;
        end
    end

    assign act_o = active_q;
    assign rd_o  = is_pwm ? shadow_q : active_q;

    assert_pwm_active_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && !load_pt) |=> $stable(active_q));

    assert_direct_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pwm && wr_en) |=> (active_q == $past(wdata)));
endmodule

// File: rtl/oc_guard.sv
module oc_guard
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cnt_wr,
    output logic blocked_o
);
    guard_e state_q;
    guard_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_ARMED:   if (cnt_wr) state_d = GUARD_BLOCKED;
            GUARD_BLOCKED: if (tick && !cnt_wr) state_d = GUARD_ARMED;
            default:       state_d = GUARD_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GUARD_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        blocked_o = 1'b0;
        unique case (state_q)
            GUARD_ARMED:   blocked_o = cnt_wr;
            GUARD_BLOCKED: blocked_o = 1'b1;
            default:       blocked_o = 1'b1;
        endcase
    end

    assert_stopped_stays_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_o && !tick) |=> blocked_o);
endmodule

// File: rtl/oc_wave.sv
module oc_wave
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmo_e cmo,
    input  logic apply,
    input  logic pin_dir,
    input  logic pin_data,
    output logic wave_o,
    output logic pin_o
);
    logic wave_q;
    logic wave_d;

    always_comb begin
        wave_d = wave_q;
        if (apply) begin
            unique case (cmo)
                CMO_OFF:    wave_d = wave_q;
                CMO_TOGGLE: wave_d = !wave_q;
                CMO_CLEAR:  wave_d = 1'b0;
                CMO_SET:    wave_d = 1'b1;
                default:    wave_d = wave_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign wave_o = wave_q;
    assign pin_o  = ((cmo != CMO_OFF) && pin_dir) ? wave_q : pin_data;

    assert_off_holds_wave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmo == CMO_OFF) |=> $stable(wave_q));

    assert_no_apply_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(wave_q));
endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wgm,
    input  logic [1:0]   cmo,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_rdata,
    input  logic         cnt_wr,
    input  logic         force_oc,
    input  logic         flag_clr,
    output logic         flag,
    output logic         cnt_clear,
    output logic         wave,
    input  logic         pin_dir,
    input  logic         pin_data,
    output logic         pin_out
);
    wgm_e         wgm_m;
    cmo_e         cmo_m;
    logic [W-1:0] active;
    logic         blocked;
    logic         hit;
    logic         apply;
    logic         flag_q;

    assign wgm_m = wgm_e'(wgm);
    assign cmo_m = cmo_e'(cmo);

    oc_cmp_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wgm(wgm_m), .tick(tick),
        .at_top(at_top), .at_bottom(at_bottom), .wr_en(cmp_wr),
        .wdata(cmp_wdata), .act_o(active), .rd_o(cmp_rdata)
    );

    oc_guard u_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
        .blocked_o(blocked)
    );

    assign hit   = tick && (cnt == active) && !blocked;
    assign apply = hit || (force_oc && !wgm[1]);

    oc_wave u_wave (
        .clk(clk), .rst_n(rst_n), .cmo(cmo_m), .apply(apply),
        .pin_dir(pin_dir), .pin_data(pin_data), .wave_o(wave), .pin_o(pin_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign flag      = flag_q;
    assign cnt_clear = hit && (wgm_m == WGM_CTC);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!flag && !wave));

    assert_clear_wins_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag);

    assert_write_blocks_next_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr ##1 (tick && !flag)) |=> !flag);

    assert_force_sets_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_oc && !tick && !flag) |=> !flag);
endmodule

// File: tb/tb_oc_unit.sv
module tb_oc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 0, at_top = 0, at_bottom = 0;
    logic [7:0] cnt = 0;
    logic [1:0] wgm = 0, cmo = 0;
    logic       cmp_wr = 0, cnt_wr = 0, force_oc = 0, flag_clr = 0;
    logic [7:0] cmp_wdata = 0;
    logic       pin_dir = 0, pin_data = 0;
    logic [7:0] cmp_rdata;
    logic       flag, cnt_clear, wave, pin_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_buf = 0, m_act = 0;
    logic       m_flag = 0, m_wave = 0, m_blk = 0;

    always #2.5 clk = ~clk;

    oc_unit dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .at_top(at_top),
        .at_bottom(at_bottom), .wgm(wgm), .cmo(cmo), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata), .cnt_wr(cnt_wr),
        .force_oc(force_oc), .flag_clr(flag_clr), .flag(flag),
        .cnt_clear(cnt_clear), .wave(wave), .pin_dir(pin_dir),
        .pin_data(pin_data), .pin_out(pin_out)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic exp_hit();
        return tick && (cnt == m_act) && !(cnt_wr || m_blk);
    endfunction

    function automatic logic exp_wave_next(logic hit_now);
        logic app;
        app = hit_now || (force_oc && !wgm[1]);
        if (!app) return m_wave;
        case (cmo)
            2'd1:    return !m_wave;
            2'd2:    return 1'b0;
            2'd3:    return 1'b1;
            default: return m_wave;
        endcase
    endfunction

    function automatic logic exp_pin();
        return (cmo != 2'd0 && pin_dir) ? m_wave : pin_data;
    endfunction

    // Inputs are already driven (after negedge); check and advance one clock.
    task automatic step();
        logic h, lp, pwm;
        logic [7:0] n_buf, n_act;
        logic n_flag, n_wave, n_blk;
        #1;
        pwm = wgm[1];
        h   = exp_hit();
        chk(pwm ? "R3 rdata shadow" : "R2 rdata active", cmp_rdata, pwm ? m_buf : m_act);
        chk("R9 cnt_clear", {7'd0, cnt_clear}, {7'd0, h && wgm == 2'd1});
        chk("R10 pin_out", {7'd0, pin_out}, {7'd0, exp_pin()});
        lp     = tick && ((wgm == 2'd2 && at_bottom) || (wgm == 2'd3 && at_top));
        n_buf  = cmp_wr ? cmp_wdata : m_buf;
        n_act  = (!pwm && cmp_wr) ? cmp_wdata : ((pwm && lp) ? m_buf : m_act);
        n_blk  = cnt_wr ? 1'b1 : (tick ? 1'b0 : m_blk);
        n_flag = h ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
        n_wave = exp_wave_next(h);
        @(posedge clk);
        m_buf = n_buf; m_act = n_act; m_blk = n_blk; m_flag = n_flag; m_wave = n_wave;
        @(negedge clk);
        chk("R5 flag", {7'd0, flag}, {7'd0, m_flag});
        chk("R6/R7/R11 wave", {7'd0, wave}, {7'd0, m_wave});
    endtask

    task automatic idle();
        tick = 0; cmp_wr = 0; cnt_wr = 0; force_oc = 0; flag_clr = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flag", {7'd0, flag}, 8'd0);
        chk("R1 wave", {7'd0, wave}, 8'd0);
        chk("R1 cnt_clear", {7'd0, cnt_clear}, 8'd0);
        chk("R1 rdata", cmp_rdata, 8'd0);
        rst_n = 1;
        @(negedge clk);

        // R2 direct write in normal mode, then hit sets flag (R5)
        wgm = 0; cmo = 2'd3; pin_dir = 1; cmp_wr = 1; cmp_wdata = 8'd5; step();
        idle(); cnt = 5; tick = 1; step();
        chk("R5 flag set by hit", {7'd0, flag}, 8'd1);
        chk("R6 set action", {7'd0, wave}, 8'd1);
        // R5 clear in same cycle as hit: hit wins
        flag_clr = 1; step();
        chk("R5 hit beats clear", {7'd0, flag}, 8'd1);
        tick = 0; step();
        chk("R5 clear", {7'd0, flag}, 8'd0);

        // R8 counter write while stopped: suppression persists
        idle(); cnt_wr = 1; step();
        idle(); repeat (5) step();
        cmo = 2'd2; tick = 1; step();
        chk("R8 hit suppressed", {7'd0, flag}, 8'd0);
        chk("R8 wave unchanged", {7'd0, wave}, 8'd1);
        step();
        chk("R8 armed again", {7'd0, flag}, 8'd1);

        // R7 force in normal mode: wave toggles, no flag
        idle(); flag_clr = 1; step();
        idle(); cmo = 2'd1; force_oc = 1; step();
        chk("R7 force toggles", {7'd0, wave}, 8'd1);
        chk("R7 force no flag", {7'd0, flag}, 8'd0);
        // R7 force ignored in PWM; R11 wave kept on mode change
        idle(); wgm = 2'd2; force_oc = 1; cnt = 9; step();
        chk("R7/R11 pwm force ignored", {7'd0, wave}, 8'd1);

        // R3/R4 shadow loading at bottom in mode 2
        idle(); cmp_wr = 1; cmp_wdata = 8'd9; step();
        idle(); tick = 1; cnt = 8; step();
        chk("R3 shadow readback", cmp_rdata, 8'd9);
        at_bottom = 1; cnt = 0; step();
        idle(); at_bottom = 0; wgm = 2'd0; #1;
        chk("R4 bottom load", cmp_rdata, 8'd9);
        // R4 load at top in mode 3
        wgm = 2'd3; cmp_wr = 1; cmp_wdata = 8'd3; step();
        idle(); tick = 1; at_bottom = 1; step();
        at_bottom = 0; at_top = 1; step();
        idle(); at_top = 0; wgm = 2'd1; #1;
        chk("R4 top load", cmp_rdata, 8'd3);
        // R9 CTC hit
        cnt = 3; tick = 1; step();
        idle(); step();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 60 == 0) wgm = 2'($urandom_range(0, 3));
            cmo       = 2'($urandom_range(0, 3));
            tick      = ($urandom_range(0, 99) < 45);
            cnt       = 8'($urandom_range(0, 7));
            at_bottom = (cnt == 0);
            at_top    = (cnt == 7);
            cmp_wr    = ($urandom_range(0, 99) < 15);
            cmp_wdata = 8'($urandom_range(0, 7));
            cnt_wr    = ($urandom_range(0, 99) < 10);
            force_oc  = ($urandom_range(0, 99) < 10);
            flag_clr  = ($urandom_range(0, 99) < 12);
            pin_dir   = 1'($urandom_range(0, 1));
            pin_data  = 1'($urandom_range(0, 1));
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule